// File: doc/BRIEF.md
# Faulted Bus Cycle Replay Controller

This controller runs when a processor returns from a bus-fault handler. On a start pulse it takes the status flags saved in the exception frame, along with the data address and direction and the two prefetch addresses. It then works out which of the interrupted bus cycles must be issued again, and drives them to a simple bus master one at a time. The master answers each request with either an acknowledge or a fault.

The handler controls the outcome by which flags it leaves set. A frame recorded as an address error is refused. A locked read-modify-write is restarted from its read phase. If any replayed cycle faults again, the controller drops the frame and raises a fresh fault that carries the new fault's details. When every required replay completes cleanly, the controller gives a one-clock done pulse and reports its pending flags as clear.

Top module: `replay_ctrl`

## Requirements
- R1: When `sw_data_fault` is set and `sw_locked` is clear, exactly one data cycle is replayed. It uses `data_addr`, has `bus_write` equal to `sw_data_write`, and has `bus_lock` low.
- R2: When a prefetch stage has both its fault flag and its rerun flag set, one read cycle (`bus_write`=0) is replayed at that stage's prefetch address.
- R3: When a prefetch stage has its rerun flag set and its fault flag clear, its read is replayed only if that stage's `need_*` input was high at the start pulse.
- R4: When no replay is required (all flags clear, or fault flags set with their rerun flags clear), no request is issued and `done` pulses two clocks after the start edge.
- R5: A start with `sw_addr_err` set issues no request and pulses `reject` for one clock, whatever the other flags say.
- R6: If a replayed cycle receives `bus_fault`, no further request is issued. `refault` then pulses for one clock with `refault_src` (0 data, 1 stage B, 2 stage C), `refault_addr` and `refault_write` describing the faulting cycle, and `pend` reads 0.
- R7: When `sw_data_fault` and `sw_locked` are both set, the whole locked sequence is replayed: a read, then a write, both at `data_addr` with `bus_lock` high.
- R8: Every request with `bus_lock` high has `bus_prot_write` high. Otherwise `bus_prot_write` equals `bus_write`.
- R9: Replays are issued in the order data, stage B, stage C. Only one request is outstanding at a time, and it is held with a stable address until it is acknowledged or faulted.
- R10: After the last clean acknowledge, `done` pulses for exactly one clock, two clocks after that acknowledge edge. `pend` (bit 0 data, bit 1 stage B, bit 2 stage C) reads 0 at that point.
- R11: Synchronous active-high `rst` returns the controller to idle. No request is pending and no pulse output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Return-from-exception begins; frame inputs are sampled |
| sw_data_fault | input | 1 | Data cycle fault flag |
| sw_fault_b | input | 1 | Stage B fault flag |
| sw_rerun_b | input | 1 | Stage B rerun flag |
| sw_fault_c | input | 1 | Stage C fault flag |
| sw_rerun_c | input | 1 | Stage C rerun flag |
| sw_addr_err | input | 1 | Fault was an address error |
| sw_locked | input | 1 | Faulted access belonged to a locked read-modify-write |
| sw_data_write | input | 1 | Faulted data cycle was a write |
| data_addr | input | AW | Faulted data address |
| pf_addr_b | input | AW | Stage B prefetch address |
| pf_addr_c | input | AW | Stage C prefetch address |
| need_b | input | 1 | Stage B is required by the pipe |
| need_c | input | 1 | Stage C is required by the pipe |
| bus_req | output | 1 | Request to the bus master |
| bus_addr | output | AW | Request address |
| bus_write | output | 1 | Request direction, 1 = write |
| bus_lock | output | 1 | Locked-sequence indication |
| bus_prot_write | output | 1 | Direction presented for protection checks |
| bus_ack | input | 1 | Request completed |
| bus_fault | input | 1 | Request terminated by a bus fault |
| done | output | 1 | All replays completed cleanly (pulse) |
| reject | output | 1 | Frame refused as an address error (pulse) |
| refault | output | 1 | New bus-error exception (pulse) |
| refault_src | output | 2 | Source of the new fault |
| refault_addr | output | AW | Address of the new fault |
| refault_write | output | 1 | Direction of the new fault |
| pend | output | 3 | Replays still outstanding |

## Verification
Some properties are checked on every cycle:
- a request holds its address until it is answered, and a fault drops the request while raising `refault`;
- locked cycles always present as writes for protection;
- `done` never lasts two clocks and coincides with empty pending flags;
- a reject never overlaps a request;
- reset clears the request and the pulses.

Other properties only the bench scenarios can show:
- whether the right cycles are chosen for each flag combination, including the effect of the stage-needed inputs;
- the data, B, C ordering;
- the read-then-write restart of a locked sequence;
- the exact cycle of `done` and the contents of the refault report.

// File: rtl/rpl_pkg.sv
package rpl_pkg;
  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_PFB  = 2'd1,
    SRC_PFC  = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_WAIT = 2'd2
  } st_e;

  typedef struct packed {
    logic data_fault;
    logic fault_b;
    logic rerun_b;
    logic fault_c;
    logic rerun_c;
    logic addr_err;
    logic locked;
    logic data_write;
  } frame_t;

  localparam int NSRC = 3;
endpackage

// File: rtl/rpl_decode.sv
module rpl_decode
  import rpl_pkg::*;
(
  input  frame_t          fr,
  input  logic            need_b,
  input  logic            need_c,
  output logic [NSRC-1:0] want
);
  logic [1:0] st_fault, st_rerun, st_need;

  assign st_fault = {fr.fault_c, fr.fault_b};
  assign st_rerun = {fr.rerun_c, fr.rerun_b};
  assign st_need  = {need_c, need_b};

  assign want[0] = fr.data_fault;

  // A stage replays when its rerun flag survived the handler and
  // either it still faults or the pipe needs it.
  for (genvar s = 0; s < 2; s++) begin : g_stage
    assign want[s+1] = st_rerun[s] & (st_fault[s] | st_need[s]);
  end
endmodule

// File: rtl/rpl_seq.sv
module rpl_seq
  import rpl_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  frame_t          fr,
  input  logic [NSRC-1:0] want,
  input  logic [AW-1:0]   data_addr,
  input  logic [AW-1:0]   pf_addr_b,
  input  logic [AW-1:0]   pf_addr_c,
  output logic            bus_req,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_write,
  output logic            bus_lock,
  output logic            bus_prot_write,
  input  logic            bus_ack,
  input  logic            bus_fault,
  output logic            done,
  output logic            reject,
  output logic            refault,
  output logic [1:0]      refault_src,
  output logic [AW-1:0]   refault_addr,
  output logic            refault_write,
  output logic [NSRC-1:0] pend
);
  st_e           st_q;
  src_e          cur_q;
  logic [AW-1:0] daddr_q, baddr_q, caddr_q;
  logic          locked_q, dwr_q, rmw_wr_q;
  logic          data_wr;

  // Locked sequences restart at the read phase; the write phase follows.
  assign data_wr = locked_q ? rmw_wr_q : dwr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= ST_IDLE;
      cur_q          <= SRC_DATA;
      pend           <= '0;
      daddr_q        <= '0;
      baddr_q        <= '0;
      caddr_q        <= '0;
      locked_q       <= 1'b0;
      dwr_q          <= 1'b0;
      rmw_wr_q       <= 1'b0;
      bus_req        <= 1'b0;
      bus_addr       <= '0;
      bus_write      <= 1'b0;
      bus_lock       <= 1'b0;
      bus_prot_write <= 1'b0;
      done           <= 1'b0;
      reject         <= 1'b0;
      refault        <= 1'b0;
      refault_src    <= 2'd0;
      refault_addr   <= '0;
      refault_write  <= 1'b0;
    end else begin
      done    <= 1'b0;
      reject  <= 1'b0;
      refault <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (fr.addr_err) begin
              reject <= 1'b1;
            end else begin
              pend     <= want;
              daddr_q  <= data_addr;
              baddr_q  <= pf_addr_b;
              caddr_q  <= pf_addr_c;
              locked_q <= fr.locked;
              dwr_q    <= fr.data_write;
              rmw_wr_q <= 1'b0;
              st_q     <= ST_ARB;
            end
          end
        end
        ST_ARB: begin
          if (pend[0]) begin
            bus_req        <= 1'b1;
            bus_addr       <= daddr_q;
            bus_write      <= data_wr;
            bus_lock       <= locked_q;
            bus_prot_write <= data_wr | locked_q;
            cur_q          <= SRC_DATA;
            st_q           <= ST_WAIT;
          end else if (pend[1]) begin
            bus_req        <= 1'b1;
            bus_addr       <= baddr_q;
            bus_write      <= 1'b0;
            bus_lock       <= 1'b0;
            bus_prot_write <= 1'b0;
            cur_q          <= SRC_PFB;
            st_q           <= ST_WAIT;
          end else if (pend[2]) begin
            bus_req        <= 1'b1;
            bus_addr       <= caddr_q;
            bus_write      <= 1'b0;
            bus_lock       <= 1'b0;
            bus_prot_write <= 1'b0;
            cur_q          <= SRC_PFC;
            st_q           <= ST_WAIT;
          end else begin
            done <= 1'b1;
            st_q <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (bus_fault) begin
            bus_req       <= 1'b0;
            bus_lock      <= 1'b0;
            refault       <= 1'b1;
            refault_src   <= cur_q;
            refault_addr  <= bus_addr;
            refault_write <= bus_write;
            pend          <= '0;
            st_q          <= ST_IDLE;
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            st_q    <= ST_ARB;
            if (cur_q == SRC_DATA && locked_q && !rmw_wr_q) begin
              rmw_wr_q <= 1'b1;
            end else begin
              bus_lock <= 1'b0;
              case (cur_q)
                SRC_DATA: pend[0] <= 1'b0;
                SRC_PFB:  pend[1] <= 1'b0;
                default:  pend[2] <= 1'b0;
              endcase
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/replay_ctrl.sv
module replay_ctrl
  import rpl_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          sw_data_fault,
  input  logic          sw_fault_b,
  input  logic          sw_rerun_b,
  input  logic          sw_fault_c,
  input  logic          sw_rerun_c,
  input  logic          sw_addr_err,
  input  logic          sw_locked,
  input  logic          sw_data_write,
  input  logic [AW-1:0] data_addr,
  input  logic [AW-1:0] pf_addr_b,
  input  logic [AW-1:0] pf_addr_c,
  input  logic          need_b,
  input  logic          need_c,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic          bus_lock,
  output logic          bus_prot_write,
  input  logic          bus_ack,
  input  logic          bus_fault,
  output logic          done,
  output logic          reject,
  output logic          refault,
  output logic [1:0]    refault_src,
  output logic [AW-1:0] refault_addr,
  output logic          refault_write,
  output logic [2:0]    pend
);
  frame_t          fr;
  logic [NSRC-1:0] want;

  assign fr = '{data_fault: sw_data_fault, fault_b: sw_fault_b,
                rerun_b: sw_rerun_b, fault_c: sw_fault_c,
                rerun_c: sw_rerun_c, addr_err: sw_addr_err,
                locked: sw_locked, data_write: sw_data_write};

  rpl_decode u_dec (
    .fr     (fr),
    .need_b (need_b),
    .need_c (need_c),
    .want   (want)
  );

  rpl_seq #(.AW(AW)) u_seq (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .fr             (fr),
    .want           (want),
    .data_addr      (data_addr),
    .pf_addr_b      (pf_addr_b),
    .pf_addr_c      (pf_addr_c),
    .bus_req        (bus_req),
    .bus_addr       (bus_addr),
    .bus_write      (bus_write),
    .bus_lock       (bus_lock),
    .bus_prot_write (bus_prot_write),
    .bus_ack        (bus_ack),
    .bus_fault      (bus_fault),
    .done           (done),
    .reject         (reject),
    .refault        (refault),
    .refault_src    (refault_src),
    .refault_addr   (refault_addr),
    .refault_write  (refault_write),
    .pend           (pend)
  );
endmodule

// File: rtl/rpl_chk.sv
module rpl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic [AW-1:0] bus_addr,
  input logic          bus_lock,
  input logic          bus_prot_write,
  input logic          bus_ack,
  input logic          bus_fault,
  input logic          done,
  input logic          reject,
  input logic          refault,
  input logic [2:0]    pend
);
  // R9: an unanswered request stays up with the same address
  a_r9_hold_req: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack && !bus_fault |=> bus_req && $stable(bus_addr));

  // R8: locked cycles present as writes for protection
  a_r8_lock_prot: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_lock |-> bus_prot_write);

  // R6: a fault ends the request and raises a new fault
  a_r6_fault_drop: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_fault |=> !bus_req && refault && pend == 3'b000);

  // R10: done lasts one clock with nothing pending
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_done_clear: assert property (@(posedge clk) disable iff (rst)
    done |-> pend == 3'b000 && !bus_req);

  // R5: a rejected frame issues nothing
  a_r5_reject_quiet: assert property (@(posedge clk) disable iff (rst)
    reject |-> !bus_req && !done && !refault);

  // R11: reset idles the controller
  a_r11_reset_idle: assert property (@(posedge clk)
    rst |=> !bus_req && !done && !reject && !refault && pend == 3'b000);
endmodule

bind replay_ctrl rpl_chk #(.AW(AW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_req        (bus_req),
  .bus_addr       (bus_addr),
  .bus_lock       (bus_lock),
  .bus_prot_write (bus_prot_write),
  .bus_ack        (bus_ack),
  .bus_fault      (bus_fault),
  .done           (done),
  .reject         (reject),
  .refault        (refault),
  .pend           (pend)
);

// File: tb/tb_replay_ctrl.sv
module tb_replay_ctrl;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic sw_data_fault = 0, sw_fault_b = 0, sw_rerun_b = 0, sw_fault_c = 0;
  logic sw_rerun_c = 0, sw_addr_err = 0, sw_locked = 0, sw_data_write = 0;
  logic [AW-1:0] data_addr = '0, pf_addr_b = '0, pf_addr_c = '0;
  logic need_b = 0, need_c = 0;
  logic bus_ack = 0, bus_fault = 0;
  logic bus_req, bus_write, bus_lock, bus_prot_write;
  logic [AW-1:0] bus_addr, refault_addr;
  logic done, reject, refault, refault_write;
  logic [1:0] refault_src;
  logic [2:0] pend;

  always #2 clk = ~clk;

  replay_ctrl #(.AW(AW)) dut (.*);

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [AW-1:0] a;
    logic          w;
    logic          l;
    int            src;
  } xact_t;
  xact_t expq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic setf(input bit df, input bit fb, input bit rb, input bit fc,
                      input bit rc, input bit ae, input bit lk, input bit dw,
                      input bit nb, input bit nc);
    sw_data_fault = df; sw_fault_b = fb; sw_rerun_b = rb; sw_fault_c = fc;
    sw_rerun_c = rc; sw_addr_err = ae; sw_locked = lk; sw_data_write = dw;
    need_b = nb; need_c = nc;
  endtask

  // Reference model: the list of replays the requirements demand.
  task automatic build();
    expq.delete();
    if (sw_data_fault) begin
      if (sw_locked) begin
        expq.push_back('{data_addr, 1'b0, 1'b1, 0});
        expq.push_back('{data_addr, 1'b1, 1'b1, 0});
      end else begin
        expq.push_back('{data_addr, sw_data_write, 1'b0, 0});
      end
    end
    if (sw_rerun_b && (sw_fault_b || need_b)) expq.push_back('{pf_addr_b, 1'b0, 1'b0, 1});
    if (sw_rerun_c && (sw_fault_c || need_c)) expq.push_back('{pf_addr_c, 1'b0, 1'b0, 2});
  endtask

  task automatic run(input string req, input int fault_at);
    int n = 0;
    int end_cyc;
    bit faulted = 0, resp = 0, ended = 0;
    xact_t fx;
    build();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (sw_addr_err) begin
      chk(reject == 1'b1, "R5", "reject pulse", reject, 1);
      chk(bus_req == 1'b0 && pend == 3'b000, "R5", "no request", bus_req, 0);
      @(negedge clk);
      chk(reject == 1'b0 && bus_req == 1'b0, "R5", "reject one clock", reject, 0);
      return;
    end
    end_cyc = (expq.size() == 0) ? 1 : -1;
    for (int cyc = 0; cyc < 300 && !ended; cyc++) begin
      if (resp) begin
        chk(bus_req == 1'b0, "R9", "request dropped after answer", bus_req, 0);
        bus_ack = 1'b0;
        bus_fault = 1'b0;
        resp = 0;
      end
      if (cyc != end_cyc) begin
        if (done || refault || reject) begin
          chk(0, "R10", "early pulse", {done, refault, reject}, 0);
        end
      end
      if (bus_req) begin
        if (n >= expq.size()) begin
          chk(0, "R9", "unexpected request", bus_addr, 0);
        end else begin
          chk(bus_addr == expq[n].a, req, "addr", bus_addr, expq[n].a);
          chk(bus_write == expq[n].w, req, "write", bus_write, expq[n].w);
          chk(bus_lock == expq[n].l, "R7", "lock", bus_lock, expq[n].l);
          chk(bus_prot_write == (expq[n].w | expq[n].l), "R8", "prot write",
              bus_prot_write, expq[n].w | expq[n].l);
          if (n == fault_at) begin
            bus_fault = 1'b1;
            faulted = 1;
            fx = expq[n];
            end_cyc = cyc + 1;
          end else begin
            bus_ack = 1'b1;
            if (n == expq.size() - 1) end_cyc = cyc + 2;
          end
          n++;
          resp = 1;
        end
      end
      if (cyc == end_cyc) begin
        ended = 1;
        chk(pend == 3'b000, faulted ? "R6" : "R10", "pend clear", pend, 0);
        if (faulted) begin
          chk(refault && !done, "R6", "refault pulse", refault, 1);
          chk(refault_src == fx.src[1:0], "R6", "refault src", refault_src, fx.src);
          chk(refault_addr == fx.a, "R6", "refault addr", refault_addr, fx.a);
          chk(refault_write == fx.w, "R6", "refault write", refault_write, fx.w);
        end else begin
          chk(done && !refault, req, "done on time", done, 1);
        end
      end
      @(negedge clk);
    end
    chk(ended, req, "scenario ended", ended, 1);
    chk(n == (fault_at < 0 ? expq.size() : fault_at + 1), "R9", "request count",
        n, fault_at < 0 ? expq.size() : fault_at + 1);
    chk(!done && !refault && !bus_req, "R10", "single pulse, idle after",
        {done, refault, bus_req}, 0);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_req && !done && !reject && !refault && pend == 0, "R11",
        "reset state", {bus_req, done, pend}, 0);

    data_addr = 32'h1000_0040; pf_addr_b = 32'h0000_2002; pf_addr_c = 32'h0000_2004;

    setf(0,0,0,0,0,0,0,0,1,1); run("R4", -1);        // all cleared
    setf(0,1,0,1,0,0,0,0,1,1); run("R4", -1);        // faults kept, reruns cleared
    setf(1,0,0,0,0,0,0,1,0,0); run("R1", -1);        // data write replay
    setf(1,0,0,0,0,0,0,0,0,0); run("R1", -1);        // data read replay
    setf(0,1,1,1,1,0,0,0,0,0); run("R2", -1);        // both prefetches
    setf(0,0,1,0,1,0,0,0,0,1); run("R3", -1);        // rerun only, C needed
    setf(0,0,1,0,1,0,0,0,1,0); run("R3", -1);        // rerun only, B needed
    setf(1,0,0,0,0,0,1,0,0,0); run("R7", -1);        // locked restart
    setf(1,1,1,1,1,0,0,1,0,0); run("R9", -1);        // full order
    setf(1,1,1,1,1,1,0,0,1,1); run("R5", -1);        // address error
    setf(1,1,1,1,1,0,0,1,0,0); run("R6", 1);         // fault on stage B
    setf(1,0,0,0,0,0,1,0,0,0); run("R6", 1);         // fault on locked write
    setf(0,0,0,1,1,0,0,0,0,0); run("R6", 0);         // fault on stage C

    // R11: reset in the middle of a replay
    setf(0,1,1,0,0,0,0,0,0,0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(bus_req == 1'b1, "R11", "request before reset", bus_req, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!bus_req && pend == 0 && !done, "R11", "reset mid-replay",
        {bus_req, pend}, 0);
    repeat (3) @(negedge clk);
    chk(!bus_req && !done && !refault, "R11", "idle after reset",
        {bus_req, done, refault}, 0);

    summary();
    $finish;
  end
endmodule